// File: doc/BRIEF.md
# DMA Channel Control and Status Register

This block holds the control and status state of a single DMA channel. Software programs a transfer count and sets the channel enable. Once the channel starts, each completed-transfer strobe from the data mover decrements a private counter. When the counter runs out, a sticky end flag is raised. When the interrupt enable is also set, the flag drives an interrupt line.

If the run stops for any other reason, the end flag is left clear:
- a non-maskable interrupt,
- an address error,
- the global master enable going low,
- software clearing the channel enable.

While the end flag is set, the channel cannot start again. Software must write the flag back to 0 first.

A write-only command bit flushes the channel's request queue, including external requests already accepted. It takes effect only when two global mode inputs are both high. The flush leaves the block as a one-cycle pulse.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset:
  - the enable, end flag, interrupt enable, count register and live counter are all 0;
  - `chan_active` is 0;
  - `irq` is 0.
- R2: Register port, address 0, control word.
  - Bit 0 is the channel enable and bit 2 is the interrupt enable; both are stored as written.
  - Bit 1 reads as the end flag.
  - Bit 3 is the queue-clear command.
  - All other read bits are 0.
- R3: Channel start.
  - Address 1 holds the programmed count and address 2 reads the live counter.
  - The channel goes active on the edge that samples all of the following: the channel idle, enable 1, end flag 0, `master_en` 1, no abort input, and a programmed count that is not zero.
  - On that same edge the live counter loads the programmed count.
- R4: Each `xfer_done` sampled while active (and no stop cause) decrements the live counter by one. `xfer_done` while idle leaves the counter unchanged.
- R5: The strobe that takes the live counter from 1 to 0 has two effects on the same edge: it sets the end flag and it clears `chan_active`.
- R6: Any stop cause while active clears `chan_active` and leaves the end flag 0. The stop causes are:
  - `abort_nmi`;
  - `abort_addr_err`;
  - `master_en` low;
  - enable 0.

  An `abort_nmi` or `abort_addr_err` while active also clears the enable.
- R7: While the end flag is 1, the channel does not become active even with the enable at 1.
- R8: A software write to the control word with bit 1 = 0 clears the end flag. Bit 1 = 1 leaves it unchanged. A completion on the same edge wins over the clear.
- R9: `irq` equals interrupt enable AND end flag, so it stays high until software clears either bit.
- R10: `q_clr_pulse` is high in the cycle of a control-word write with bit 3 = 1 only when `mode_direct` and `mode_pair` are both 1. Otherwise it is low.
- R11: Bit 3 of the control word always reads 0 and is not retained.
- R12: A programmed count of 0 never starts the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address: 0 control, 1 count, 2 live counter |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| xfer_done | input | 1 | One completed transfer |
| abort_nmi | input | 1 | Non-maskable interrupt abort |
| abort_addr_err | input | 1 | Address error abort |
| master_en | input | 1 | Global master enable |
| mode_direct | input | 1 | Global direct-transfer mode bit |
| mode_pair | input | 1 | Companion global mode bit |
| q_clr_pulse | output | 1 | Request-queue flush pulse |
| chan_active | output | 1 | Channel in active transfer state |
| irq | output | 1 | Transfer-end interrupt |

## Verification
The bench targets the following corner cases:
- **Abort versus completion.** An abort must leave the end flag clear; a design that set it on every stop would raise a false interrupt.
- **Restart while the flag is set.** Re-enabling with the flag still set must not restart the channel. A design that ignored the flag would run the same buffer twice.
- **Software write of 1 to the flag.** Writing 1 must not set the end flag. A design that stored the bit would let software fake a completion.
- **Mode gating of the queue clear.** The flush must not pulse with either mode bit low. A design that missed the gating would drop queued requests.
- **Zero count.** A zero count must not start the channel. A design that started on it would count down through wrap-around and hang active for a full counter range.

Random traffic against a per-cycle reference model covers combinations of these, including a completion on the same edge as a software clear.

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              xfer_done,
  input  logic              abort_nmi,
  input  logic              abort_addr_err,
  input  logic              master_en,
  input  logic              mode_direct,
  input  logic              mode_pair,
  output logic              q_clr_pulse,
  output logic              chan_active,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_LIVE = ADDR_W'(2);

  logic en_q, te_q, ie_q, act_q;
  logic [CNT_W-1:0] cnt_reg_q, tcnt_q;

  logic wr_ctl, wr_cnt, hard_abort, stop, start, last;
  logic unused_wdata;

  assign wr_ctl     = reg_wr && (reg_addr == A_CTL);
  assign wr_cnt     = reg_wr && (reg_addr == A_CNT);
  assign hard_abort = abort_nmi | abort_addr_err;
  assign stop       = hard_abort | ~master_en | ~en_q;
  assign start      = ~act_q & en_q & ~te_q & master_en & ~hard_abort & (cnt_reg_q != '0);
  assign last       = act_q & ~stop & xfer_done & (tcnt_q == CNT_W'(1));

  assign q_clr_pulse  = wr_ctl & reg_wdata[3] & mode_direct & mode_pair;
  assign chan_active  = act_q;
  assign irq          = ie_q & te_q;
  assign unused_wdata = ^reg_wdata[DATA_W-1:CNT_W];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTL:   reg_rdata[2:0] = {ie_q, te_q, en_q};
      A_CNT:   reg_rdata[CNT_W-1:0] = cnt_reg_q;
      A_LIVE:  reg_rdata[CNT_W-1:0] = tcnt_q;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      te_q      <= 1'b0;
      ie_q      <= 1'b0;
      act_q     <= 1'b0;
      cnt_reg_q <= '0;
      tcnt_q    <= '0;
    end else begin
      if (wr_ctl) begin
        en_q <= reg_wdata[0];
        ie_q <= reg_wdata[2];
        if (!reg_wdata[1]) te_q <= 1'b0;
      end
      if (wr_cnt) cnt_reg_q <= reg_wdata[CNT_W-1:0];
      if (act_q && hard_abort) en_q <= 1'b0;
      if (last) te_q <= 1'b1;

      if (start) begin
        act_q  <= 1'b1;
        tcnt_q <= cnt_reg_q;
      end else if (act_q) begin
        if (stop) begin
          act_q <= 1'b0;
        end else if (xfer_done) begin
          tcnt_q <= tcnt_q - CNT_W'(1);
          if (last) act_q <= 1'b0;
        end
      end
    end
  end
endmodule

module dma_chan_ctl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             act_q,
  input logic             te_q,
  input logic             en_q,
  input logic             ie_q,
  input logic [CNT_W-1:0] tcnt_q,
  input logic             xfer_done,
  input logic             abort_nmi,
  input logic             abort_addr_err,
  input logic             master_en,
  input logic             mode_direct,
  input logic             mode_pair,
  input logic             q_clr_pulse,
  input logic             irq
);
  logic any_stop;
  assign any_stop = abort_nmi | abort_addr_err | ~master_en | ~en_q;

  assert_flag_blocks_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    te_q && !act_q |=> !act_q);

  assert_abort_no_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && (abort_nmi || abort_addr_err) |=> !act_q && !te_q && !en_q);

  assert_counter_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && !xfer_done && !any_stop |=> tcnt_q == $past(tcnt_q));

  assert_flag_on_completion_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(te_q) |-> $past(act_q) && !act_q && tcnt_q == '0);

  assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ie_q && te_q);

  assert_qclr_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    q_clr_pulse |-> mode_direct && mode_pair);
endmodule

bind dma_chan_ctl dma_chan_ctl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .act_q(act_q), .te_q(te_q), .en_q(en_q), .ie_q(ie_q),
  .tcnt_q(tcnt_q), .xfer_done(xfer_done), .abort_nmi(abort_nmi),
  .abort_addr_err(abort_addr_err), .master_en(master_en),
  .mode_direct(mode_direct), .mode_pair(mode_pair),
  .q_clr_pulse(q_clr_pulse), .irq(irq)
);

// File: tb/dma_chan_ctl_test.sv
module dma_chan_ctl_test;
  localparam int DW = 32;
  localparam int CW = 16;
  localparam int AW = 2;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [AW-1:0] reg_addr = 0;
  logic [DW-1:0] reg_wdata = 0, reg_rdata;
  logic xfer_done = 0, abort_nmi = 0, abort_addr_err = 0, master_en = 1;
  logic mode_direct = 0, mode_pair = 0;
  logic q_clr_pulse, chan_active, irq;

  int vectors = 0, errors = 0;

  dma_chan_ctl #(.DATA_W(DW), .CNT_W(CW), .ADDR_W(AW)) uut (.*);

  always #4 clk = ~clk;

  logic m_en, m_te, m_ie, m_act;
  logic [CW-1:0] m_cnt, m_live;

  function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a);
    logic [DW-1:0] r = '0;
    case (a)
      2'd0: r[2:0] = {m_ie, m_te, m_en};
      2'd1: r[CW-1:0] = m_cnt;
      2'd2: r[CW-1:0] = m_live;
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic exp_qclr();
    return reg_wr && reg_addr == 2'd0 && reg_wdata[3] && mode_direct && mode_pair;
  endfunction

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_en = 0; m_te = 0; m_ie = 0; m_act = 0; m_cnt = 0; m_live = 0;
  endtask

  task automatic model_step();
    logic hab, stp, st, lst;
    logic n_en, n_te, n_ie, n_act;
    logic [CW-1:0] n_cnt, n_live;
    hab = abort_nmi | abort_addr_err;
    stp = hab | ~master_en | ~m_en;
    st  = !m_act && m_en && !m_te && master_en && !hab && m_cnt != 0;
    lst = m_act && !stp && xfer_done && m_live == 1;
    n_en = m_en; n_te = m_te; n_ie = m_ie; n_act = m_act; n_cnt = m_cnt; n_live = m_live;
    if (reg_wr && reg_addr == 2'd0) begin
      n_en = reg_wdata[0]; n_ie = reg_wdata[2];
      if (!reg_wdata[1]) n_te = 0;
    end
    if (reg_wr && reg_addr == 2'd1) n_cnt = reg_wdata[CW-1:0];
    if (m_act && hab) n_en = 0;
    if (lst) n_te = 1;
    if (st) begin n_act = 1; n_live = m_cnt; end
    else if (m_act) begin
      if (stp) n_act = 0;
      else if (xfer_done) begin n_live = m_live - 1; if (lst) n_act = 0; end
    end
    m_en = n_en; m_te = n_te; m_ie = n_ie; m_act = n_act; m_cnt = n_cnt; m_live = n_live;
  endtask

  task automatic cyc(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic xd, input logic nmi, input logic ae, input logic men,
                     input logic md, input logic mp);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; xfer_done = xd;
    abort_nmi = nmi; abort_addr_err = ae; master_en = men; mode_direct = md; mode_pair = mp;
    #1;
    chk(q_clr_pulse, exp_qclr(), "R10 q_clr_pulse");
    chk(reg_rdata, exp_rd(reg_addr), "R2 reg_rdata");
    chk(chan_active, m_act, "R3 chan_active");
    chk(irq, m_ie & m_te, "R9 irq");
    @(posedge clk);
    model_step();
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 1, 0, 0);
  endtask

  task automatic peek(input logic [AW-1:0] a, output logic [DW-1:0] v);
    reg_wr = 0; reg_addr = a; #1; v = reg_rdata;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    void'($urandom(32'd1357));
    model_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    peek(0, v); chk(v, 0, "R1 ctl after reset");
    peek(2, v); chk(v, 0, "R1 counter after reset");
    chk(chan_active, 0, "R1 active after reset");
    chk(irq, 0, "R1 irq after reset");
    @(negedge clk); rst_n = 1;

    cyc(1, 1, 3, 0, 0, 0, 1, 0, 0);
    cyc(1, 0, 32'h5, 0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0);
    chk(chan_active, 1, "R3 start");
    peek(2, v); chk(v, 3, "R3 reload");
    cyc(0, 0, 0, 1, 0, 0, 1, 0, 0);
    peek(2, v); chk(v, 2, "R4 decrement");
    cyc(0, 0, 0, 1, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 0, 0, 1, 0, 0);
    chk(chan_active, 0, "R5 done inactive");
    peek(0, v); chk(v[1], 1, "R5 end flag");
    chk(irq, 1, "R9 irq raised");

    cyc(1, 0, 32'h7, 0, 0, 0, 1, 0, 0);
    idle(3);
    peek(0, v); chk(v[1], 1, "R8 write 1 keeps flag");
    chk(chan_active, 0, "R7 flag blocks start");

    cyc(0, 0, 0, 1, 0, 0, 1, 0, 0);
    peek(2, v); chk(v, 0, "R4 idle strobe ignored");

    cyc(1, 0, 32'hF, 0, 0, 0, 1, 0, 1);
    cyc(1, 0, 32'hF, 0, 0, 0, 1, 1, 1);
    peek(0, v); chk(v[3], 0, "R11 qclr not retained");

    cyc(1, 0, 32'h1, 0, 0, 0, 1, 0, 0);
    peek(0, v); chk(v[1], 0, "R8 write 0 clears flag");
    chk(irq, 0, "R9 irq cleared");
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0);
    chk(chan_active, 1, "R3 restart");
    cyc(0, 0, 0, 1, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 1, 0, 1, 0, 0);
    chk(chan_active, 0, "R6 nmi abort");
    peek(0, v); chk(v[1:0], 0, "R6 no flag, enable cleared");

    cyc(1, 1, 0, 0, 0, 0, 1, 0, 0);
    cyc(1, 0, 32'h1, 0, 0, 0, 1, 0, 0);
    idle(3);
    chk(chan_active, 0, "R12 zero count");

    cyc(1, 1, 2, 0, 0, 0, 1, 0, 0);
    idle(2);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk(chan_active, 0, "R6 master disable");
    peek(0, v); chk(v[1], 0, "R6 master disable no flag");

    for (int i = 0; i < 4000; i++) begin
      logic wr, xd, nmi, ae, men, md, mp;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      wr  = ($urandom % 8) == 0;
      a   = AW'($urandom % 4);
      d   = (a == 2'd1) ? DW'($urandom % 5) : DW'($urandom % 16);
      xd  = $urandom % 2;
      nmi = ($urandom % 40) == 0;
      ae  = ($urandom % 40) == 0;
      men = ($urandom % 20) != 0;
      md  = $urandom % 2;
      mp  = $urandom % 2;
      cyc(wr, a, d, xd, nmi, ae, men, md, mp);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule